// File: doc/BRIEF.md
# SDRAM Precharge Power-Down Sequencer

This block is the power-management state machine of an SDRAM controller. A configuration bit asks for low-power operation. The block does not act on that bit at once. It keeps serving traffic until no access is pending, the refresh backlog is empty and every bank has been closed. Only then does it drop the clock-enable pin, using a POWER DOWN cycle. Because the banks are always closed first, only precharge power-down is ever used.

While powered down, the block wakes for three reasons. It wakes when an access engine raises a request. It wakes when the refresh backlog reaches its urgent level and refresh in power-down is enabled. It wakes when the power-down bit is cleared. Every wake-up raises clock-enable with NOP held on the command bus for a programmable exit time. After an access or a refresh excursion, the block re-enters power-down by itself. After the bit is cleared, it stays awake and idle.

The refresh interval timer, the data path and mode-register programming sit outside the block. The timer is seen as a one-cycle tick that adds to an internal backlog counter. The access engine is seen as a level request, a grant and an any-bank-open flag. The row-precharge, refresh-cycle and exit times are inputs set at run time.

Top module: `sdpd_top`

## Requirements
- R1: After reset, clock-enable is high, the command bus shows deselect (cs_n, ras_n, cas_n, we_n = 1111), the backlog reads 0 and the grant is high.
- R2: While an access request is held, setting the power-down bit does not lower clock-enable, and the grant stays high.
- R3: Power-down is entered only after the backlog has been emptied by AUTO REFRESH commands. The POWER DOWN cycle comes one cycle after the request when nothing is pending. Otherwise it comes trfc+1 cycles after the last AUTO REFRESH.
- R4: POWER DOWN is the NOP code 0111 with clock-enable low in the same cycle. For as long as clock-enable stays low, the command bus carries only NOP or deselect.
- R5: If any bank is open when the block wants to power down or refresh, it first issues PRECHARGE ALL (code 0010 with the A10 output high). The next AUTO REFRESH or POWER DOWN follows trp+1 cycles later.
- R6: In power-down, an access request wakes the block and the grant rises after the exit time. When the request is released, POWER DOWN is issued on the next cycle.
- R7: With refresh in power-down enabled, reaching the urgent backlog level in power-down causes a wake-up. The block then issues AUTO REFRESH until the backlog is 0 and returns to power-down.
- R8: With refresh in power-down disabled, no AUTO REFRESH is issued and clock-enable stays low while ticks accumulate.
- R9: Clearing the power-down bit in power-down raises clock-enable, and the block stays awake and idle.
- R10: On every exit, clock-enable rises with NOP (0111) on the bus. NOP is held for txp cycles, and the block is active on cycle txp+1.
- R11: Each AUTO REFRESH (code 0001) lowers the backlog by one. Consecutive AUTO REFRESH commands are exactly trfc cycles apart.
- R12: Each tick raises the backlog, which saturates at its maximum. When the backlog reaches the urgent level during normal operation, the grant drops, and AUTO REFRESH follows one cycle later and continues until the backlog is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pd_req | input | 1 | Power-down request bit |
| cfg_pd_rfsh_en | input | 1 | Refresh-in-power-down enable |
| cfg_trp | input | TIM_W | Row-precharge time in cycles (2 or more) |
| cfg_trfc | input | TIM_W | Refresh-cycle time in cycles (2 or more) |
| cfg_txp | input | TIM_W | Power-down exit time in cycles (1 or more) |
| rfsh_tick | input | 1 | One-cycle pulse from the refresh interval timer |
| acc_req | input | 1 | Access pending or in progress |
| banks_open | input | 1 | At least one bank is open |
| acc_gnt | output | 1 | Access engine may use the bus |
| sd_cke | output | 1 | SDRAM clock-enable |
| sd_cmd | output | 4 | cs_n, ras_n, cas_n, we_n from the MSB down |
| sd_a10 | output | 1 | A10 level, high for PRECHARGE ALL |
| rfsh_backlog | output | BL_W | Pending refresh count |

## Verification
Every output is decoded from registered state, so a change on an input shows on the pins one clock later. The bench therefore drives inputs at the falling edge and samples at each later falling edge. It numbers those samples from 1 and compares them with exact cycle numbers. The POWER DOWN cycle is due at 1 + open·(trp+1) + (backlog>0 ? backlog·trfc+1 : 0) after the request. AUTO REFRESH commands are due trfc apart. A wake-up shows NOP on cycles 1 through txp, the grant on cycle txp+1, and re-entry one cycle after the request is dropped. After an urgent tick, the grant drop is checked on cycle 1 and the first AUTO REFRESH on cycle 2.

// File: rtl/sdpd_pkg.sv
`timescale 1ns/1ps
package sdpd_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_PREA,
        ST_PWAIT,
        ST_AREF,
        ST_RWAIT,
        ST_PDE,
        ST_PD,
        ST_EXIT
    } pd_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PREA  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    function automatic logic cmd_is_quiet(input sd_cmd_t c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

    function automatic logic pd_holds_cke_low(input pd_state_e s);
        return (s == ST_PDE) || (s == ST_PD);
    endfunction

endpackage

// File: rtl/sdpd_backlog.sv
`timescale 1ns/1ps
module sdpd_backlog #(
    parameter int BL_W       = 4,
    parameter int URGENT_LVL = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            dec,
    output logic [BL_W-1:0] level,
    output logic            urgent,
    output logic            empty
);
    localparam logic [BL_W-1:0] LVL_MAX = '1;
    localparam logic [BL_W-1:0] LVL_URG = BL_W'(URGENT_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (level != LVL_MAX) level <= level + 1'b1;
                2'b01:   if (level != '0)      level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign urgent = (level >= LVL_URG);
    assign empty  = (level == '0);

    // R12: a tick at the maximum leaves the count pinned there
    assert_backlog_sat_R12: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_MAX && inc && !dec) |=> (level == LVL_MAX));

endmodule

// File: rtl/sdpd_wait_timer.sv
`timescale 1ns/1ps
module sdpd_wait_timer #(
    parameter int TIM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TIM_W-1:0] load_val,
    output logic             done
);
    logic [TIM_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sdpd_fsm.sv
`timescale 1ns/1ps
module sdpd_fsm
    import sdpd_pkg::*;
#(
    parameter int TIM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_req,
    input  logic             pdr_en,
    input  logic             acc_req,
    input  logic             banks_open,
    input  logic             bl_urgent,
    input  logic             bl_empty,
    input  logic             tmr_done,
    input  logic [TIM_W-1:0] cfg_trp,
    input  logic [TIM_W-1:0] cfg_trfc,
    input  logic [TIM_W-1:0] cfg_txp,
    output pd_state_e        state,
    output logic             tmr_load,
    output logic [TIM_W-1:0] tmr_val
);
    pd_state_e        nxt;
    logic             needs_rfsh;
    logic             wake;
    logic [TIM_W-1:0] trp_ld, trfc_ld, txp_ld;

    // wait states last (t-1) cycles after the one-cycle command slot
    assign trp_ld  = (cfg_trp  >= TIM_W'(2)) ? cfg_trp  - TIM_W'(2) : '0;
    assign trfc_ld = (cfg_trfc >= TIM_W'(2)) ? cfg_trfc - TIM_W'(2) : '0;
    assign txp_ld  = (cfg_txp  >= TIM_W'(1)) ? cfg_txp  - TIM_W'(1) : '0;

    assign needs_rfsh = bl_urgent || (pd_req && !bl_empty && !acc_req);
    assign wake       = !pd_req || acc_req || (pdr_en && bl_urgent);

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_ACTIVE: begin
                if (needs_rfsh)            nxt = banks_open ? ST_PREA : ST_AREF;
                else if (acc_req)          nxt = ST_ACTIVE;
                else if (pd_req)           nxt = banks_open ? ST_PREA : ST_PDE;
            end
            ST_PREA: begin
                nxt      = ST_PWAIT;
                tmr_load = 1'b1;
                tmr_val  = trp_ld;
            end
            ST_PWAIT:  if (tmr_done) nxt = ST_ACTIVE;
            ST_AREF: begin
                nxt      = ST_RWAIT;
                tmr_load = 1'b1;
                tmr_val  = trfc_ld;
            end
            ST_RWAIT:  if (tmr_done) nxt = bl_empty ? ST_ACTIVE : ST_AREF;
            ST_PDE:    nxt = ST_PD;
            ST_PD: begin
                if (wake) begin
                    nxt      = ST_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = txp_ld;
                end
            end
            ST_EXIT:   if (tmr_done) nxt = ST_ACTIVE;
            default:   nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ACTIVE;
        else     state <= nxt;
    end

    // R7: urgent level in power-down with refresh enabled leads to exit
    assert_rfsh_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PD && pdr_en && bl_urgent) |=> (state == ST_EXIT));

    // R8: with refresh disabled and the request kept, power-down is never left
    assert_pd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PD && !pdr_en && pd_req && !acc_req) |=> (state == ST_PD));

endmodule

// File: rtl/sdpd_top.sv
`timescale 1ns/1ps
module sdpd_top
    import sdpd_pkg::*;
#(
    parameter int TIM_W      = 4,
    parameter int BL_W       = 4,
    parameter int URGENT_LVL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_pd_req,
    input  logic             cfg_pd_rfsh_en,
    input  logic [TIM_W-1:0] cfg_trp,
    input  logic [TIM_W-1:0] cfg_trfc,
    input  logic [TIM_W-1:0] cfg_txp,
    input  logic             rfsh_tick,
    input  logic             acc_req,
    input  logic             banks_open,
    output logic             acc_gnt,
    output logic             sd_cke,
    output logic [3:0]       sd_cmd,
    output logic             sd_a10,
    output logic [BL_W-1:0]  rfsh_backlog
);
    pd_state_e        state;
    logic             tmr_load, tmr_done;
    logic [TIM_W-1:0] tmr_val;
    logic             bl_urgent, bl_empty;
    sd_cmd_t          cmd;

    sdpd_backlog #(.BL_W(BL_W), .URGENT_LVL(URGENT_LVL)) u_backlog (
        .clk    (clk),
        .rst    (rst),
        .inc    (rfsh_tick),
        .dec    (state == ST_AREF),
        .level  (rfsh_backlog),
        .urgent (bl_urgent),
        .empty  (bl_empty)
    );

    sdpd_wait_timer #(.TIM_W(TIM_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sdpd_fsm #(.TIM_W(TIM_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pd_req     (cfg_pd_req),
        .pdr_en     (cfg_pd_rfsh_en),
        .acc_req    (acc_req),
        .banks_open (banks_open),
        .bl_urgent  (bl_urgent),
        .bl_empty   (bl_empty),
        .tmr_done   (tmr_done),
        .cfg_trp    (cfg_trp),
        .cfg_trfc   (cfg_trfc),
        .cfg_txp    (cfg_txp),
        .state      (state),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    always_comb begin
        unique case (state)
            ST_PREA:         cmd = CMD_PREA;
            ST_AREF:         cmd = CMD_AREF;
            ST_PDE, ST_EXIT: cmd = CMD_NOP;
            default:         cmd = CMD_DESEL;
        endcase
    end

    assign sd_cmd  = cmd;
    assign sd_a10  = (state == ST_PREA);
    assign sd_cke  = !pd_holds_cke_low(state);
    assign acc_gnt = (state == ST_ACTIVE) && !bl_urgent;

    // R4: power-down entry cycle is a NOP
    assert_pd_entry_nop_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sd_cke) |-> (sd_cmd == CMD_NOP));

    // R4: only quiet codes while clock-enable is low
    assert_quiet_cke_low_R4: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> cmd_is_quiet(sd_cmd));

    // R3: entry only once drained
    assert_pd_drained_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sd_cke) |-> $past(rfsh_backlog == '0 && !acc_req && !banks_open));

    // R10: exit raises clock-enable with NOP
    assert_exit_nop_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_cke) |-> (sd_cmd == CMD_NOP));

    // R11: each refresh lowers the backlog by one
    assert_aref_dec_R11: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_AREF && !rfsh_tick) |=> (rfsh_backlog == $past(rfsh_backlog) - 1'b1));

endmodule

// File: tb/sdpd_tb.sv
`timescale 1ns/1ps
module sdpd_top_tb_top;

    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_PREA  = 4'b0010;
    localparam logic [3:0] C_AREF  = 4'b0001;
    localparam int NV = 4;
    // fields: backlog, banks open, trp, trfc
    localparam logic [15:0] VEC [NV] = '{
        {4'd0, 4'd0, 4'd2, 4'd2},
        {4'd0, 4'd1, 4'd3, 4'd2},
        {4'd2, 4'd0, 4'd2, 4'd3},
        {4'd3, 4'd1, 4'd4, 4'd5}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_pd_req = 1'b0, cfg_pd_rfsh_en = 1'b0;
    logic [3:0] cfg_trp = 4'd2, cfg_trfc = 4'd2, cfg_txp = 4'd3;
    logic rfsh_tick = 1'b0, acc_req = 1'b0, banks_open = 1'b0;
    logic acc_gnt, sd_cke, sd_a10;
    logic [3:0] sd_cmd, rfsh_backlog;

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdpd_top dut_i (
        .clk(clk), .rst(rst), .cfg_pd_req(cfg_pd_req), .cfg_pd_rfsh_en(cfg_pd_rfsh_en),
        .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc), .cfg_txp(cfg_txp), .rfsh_tick(rfsh_tick),
        .acc_req(acc_req), .banks_open(banks_open), .acc_gnt(acc_gnt), .sd_cke(sd_cke),
        .sd_cmd(sd_cmd), .sd_a10(sd_a10), .rfsh_backlog(rfsh_backlog)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_pd_req = 0; cfg_pd_rfsh_en = 0; rfsh_tick = 0;
        acc_req = 0; banks_open = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_tick();
        rfsh_tick = 1'b1;
        @(negedge clk);
        rfsh_tick = 1'b0;
    endtask

    // runs until clock-enable falls, returns its cycle and the refresh count
    task automatic run_to_pd(input string tag, input int trfc, output int pde, output int arefs);
        int last = -1;
        pde = 0; arefs = 0;
        for (int c = 1; c <= 400 && pde == 0; c++) begin
            @(negedge clk);
            if (sd_cmd == C_AREF) begin
                if (last >= 0) check({tag, " R11 refresh spacing"}, c - last, trfc);
                last = c; arefs++;
            end
            if (sd_cmd == C_PREA) begin
                check({tag, " R5 A10 on precharge"}, int'(sd_a10), 1);
                banks_open = 1'b0;
            end
            if (!sd_cke) begin
                pde = c;
                check({tag, " R4 power-down code"}, int'(sd_cmd), int'(C_NOP));
            end
        end
    endtask

    initial begin
        int pde, arefs, b, k, trp, trfc, expc;
        // table of entry scenarios
        for (int v = 0; v < NV; v++) begin
            b = int'(VEC[v][15:12]); k = int'(VEC[v][11:8]);
            trp = int'(VEC[v][7:4]); trfc = int'(VEC[v][3:0]);
            do_reset();
            cfg_trp = 4'(trp); cfg_trfc = 4'(trfc);
            for (int i = 0; i < b; i++) pulse_tick();
            banks_open = (k != 0);
            @(negedge clk);
            check("R12 backlog after ticks", int'(rfsh_backlog), b);
            cfg_pd_req = 1'b1;
            run_to_pd("vec", trfc, pde, arefs);
            expc = 1 + k * (trp + 1) + ((b > 0) ? b * trfc + 1 : 0);
            check("R3 refresh count before entry", arefs, b);
            check("R5 R3 entry cycle", pde, expc);
            check("R3 backlog empty at entry", int'(rfsh_backlog), 0);
        end

        // R1 reset state
        do_reset();
        cfg_trp = 4'd2; cfg_trfc = 4'd3; cfg_txp = 4'd3;
        check("R1 cke", int'(sd_cke), 1);
        check("R1 cmd", int'(sd_cmd), int'(C_DESEL));
        check("R1 backlog", int'(rfsh_backlog), 0);
        check("R1 grant", int'(acc_gnt), 1);

        // R2 access holds off power-down
        acc_req = 1'b1; cfg_pd_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R2 cke held", int'(sd_cke), 1);
            check("R2 grant held", int'(acc_gnt), 1);
        end
        acc_req = 1'b0;
        @(negedge clk);
        check("R2 entry after release", int'(sd_cke), 0);

        // R6 / R10 access wake
        @(negedge clk);
        acc_req = 1'b1;
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check("R10 exit NOP", int'(sd_cmd), int'(C_NOP));
            check("R10 exit cke", int'(sd_cke), 1);
            check("R6 no grant during exit", int'(acc_gnt), 0);
        end
        @(negedge clk);
        check("R6 grant after exit", int'(acc_gnt), 1);
        check("R6 bus deselect when active", int'(sd_cmd), int'(C_DESEL));
        acc_req = 1'b0;
        @(negedge clk);
        check("R6 re-entry cke", int'(sd_cke), 0);
        check("R6 re-entry code", int'(sd_cmd), int'(C_NOP));

        // R9 clear request
        @(negedge clk);
        cfg_pd_req = 1'b0;
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check("R9 R10 exit NOP", int'(sd_cmd), int'(C_NOP));
        end
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            check("R9 stays awake", int'(sd_cke), 1);
            check("R9 idle bus", int'(sd_cmd), int'(C_DESEL));
        end

        // R8 no refresh when disabled, saturation
        cfg_pd_rfsh_en = 1'b0; cfg_pd_req = 1'b1;
        @(negedge clk);
        check("R8 entered", int'(sd_cke), 0);
        for (int i = 0; i < 20; i++) begin
            pulse_tick();
            check("R8 cke stays low", int'(sd_cke), 0);
            check("R8 no refresh", int'(sd_cmd == C_AREF), 0);
        end
        @(negedge clk);
        check("R8 cke still low", int'(sd_cke), 0);
        check("R12 saturated backlog", int'(rfsh_backlog), 15);

        // R7 enable refresh in power-down
        cfg_pd_rfsh_en = 1'b1;
        run_to_pd("R7", 3, pde, arefs);
        check("R7 woke and refreshed", arefs, 15);
        check("R7 back in power-down", int'(sd_cke), 0);
        check("R7 backlog drained", int'(rfsh_backlog), 0);
        for (int i = 0; i < 4; i++) pulse_tick();
        run_to_pd("R7b", 3, pde, arefs);
        check("R7 urgent excursion refreshes", arefs, 4);

        // R12 urgent level in normal operation
        do_reset();
        cfg_trfc = 4'd2;
        acc_req = 1'b1;
        for (int i = 0; i < 3; i++) pulse_tick();
        check("R12 grant below urgent", int'(acc_gnt), 1);
        pulse_tick();
        check("R12 urgent backlog", int'(rfsh_backlog), 4);
        check("R12 grant drops", int'(acc_gnt), 0);
        @(negedge clk);
        check("R12 refresh follows", int'(sd_cmd), int'(C_AREF));
        arefs = 1;
        for (int c = 0; c < 40 && !acc_gnt; c++) begin
            @(negedge clk);
            if (sd_cmd == C_AREF) arefs++;
        end
        check("R12 R11 refresh to zero", arefs, 4);
        check("R12 grant restored", int'(acc_gnt), 1);
        check("R11 backlog zero", int'(rfsh_backlog), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule